// File: doc/BRIEF.md
# Passive-Matrix Colour Panel Timing Generator

This block produces the strobes that drive a passive-matrix colour panel from the system clock. The strobes are a data clock, a line pulse, a frame pulse, and a request strobe that tells the pixel path to present the next transfer unit. The line length, line count, blanking time and scan mode come from register fields. Software computes these fields for the panel. The horizontal field is the number of transfer units per line minus one. A transfer unit is one data-bus word, and each pixel holds three subpixels. The vertical field is the line count minus one. For a panel whose halves are driven together, this is half the panel height.

Each line has two parts. First come `hoz_val+1` data transfers, each lasting `DIV` system clocks. Then comes a blank period counted in system clocks, during which the data clock stays low and the line pulse is raised. A frame is `line_val+1` such lines. The frame pulse accompanies the line pulse of the first line only. All register fields are sampled together at each frame boundary, so a write in the middle of a frame has no effect until the next frame.

Top module: `stn_timing_gen`

## Requirements
- R1: While `rst_n` is low, `vclk`, `data_req`, `vline`, `vframe` and `scan_dual` are all 0. After release, one load cycle captures the fields and the first line begins.
- R2: Each line carries exactly `hoz_val+1` rising edges of `vclk`.
- R3: Each data transfer lasts `DIV` clocks. `vclk` is low for the first `DIV/2` clocks and high for the last `DIV/2` clocks of the transfer.
- R4: `data_req` is high for exactly one clock, and that clock comes immediately before each rising edge of `vclk`. It is never high at any other time.
- R5: After the last transfer of a line, a blank of exactly `blank_len` clocks follows, or 1 clock when `blank_len` is 0. `vclk` stays low during the blank. The distance between consecutive line pulses is therefore (blank of the earlier line) + (`hoz_val+1`)·`DIV` clocks.
- R6: `vline` rises on the first blank clock of every line and stays high for min(`VLINE_W`, blank length) clocks. `vline` is never high while `vclk` is high.
- R7: A frame holds `line_val+1` lines. `vframe` is high only during the `vline` pulse of line 0 of each frame. When `line_val` is 0, every line is line 0.
- R8: `hoz_val`, `line_val`, `blank_len` and `dual_scan` are captured together only at a frame boundary. A change made during a frame first shows in the following frame.
- R9: `scan_dual` reports the `dual_scan` value captured for the current frame (1 = halves driven together, 4-bit bus; 0 = single scan, 8-bit bus). The line count is `line_val+1` in both modes, because the field already holds the halved value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hoz_val | input | HW | Transfers per line minus one |
| line_val | input | VW | Lines per frame minus one |
| blank_len | input | BW | Blank length in system clocks |
| dual_scan | input | 1 | Scan mode select, 1 = dual scan |
| vclk | output | 1 | Data transfer clock |
| data_req | output | 1 | Request for the next transfer unit, one clock before each `vclk` rise |
| vline | output | 1 | Line pulse during the blank |
| vframe | output | 1 | Frame pulse with the first line pulse |
| scan_dual | output | 1 | Scan mode in effect for the current frame |

## Verification
The field capture and the last line's blank completion land on the same clock. That clock also starts line 0 of the next frame, so the new geometry has to govern the very next transfer while the old blank still ends the previous line. The bench provokes this by changing the fields during the final frame of each configuration. One configuration uses `line_val` = 0, so every line is both first and last, and its frame pulse, line pulse and capture all fall within one line. A scoreboard predicts, line by line, the transfer count, the spacing between line pulses (old blank + new active time), the pulse width, the frame flag and the mode. Any capture that comes too early or too late changes those values.

// File: rtl/stn_timing_gen.sv
module stn_timing_gen #(
  parameter int DIV     = 4,
  parameter int VLINE_W = 2,
  parameter int HW      = 10,
  parameter int VW      = 10,
  parameter int BW      = 8
) (
  input  logic          mclk,
  input  logic          rst_n,
  input  logic [HW-1:0] hoz_val,
  input  logic [VW-1:0] line_val,
  input  logic [BW-1:0] blank_len,
  input  logic          dual_scan,
  output logic          vclk,
  output logic          data_req,
  output logic          vline,
  output logic          vframe,
  output logic          scan_dual
);
  localparam int HALF = DIV / 2;
  localparam int DW   = (DIV > 2) ? $clog2(DIV) : 1;

  typedef enum logic [1:0] {LOAD = 2'd0, ACT = 2'd1, BLK = 2'd2} phase_t;

  phase_t        st;
  logic [DW-1:0] div;
  logic [HW-1:0] xf;
  logic [VW-1:0] ln;
  logic [BW-1:0] bc;
  logic [HW-1:0] hoz_r;
  logic [VW-1:0] lin_r;
  logic [BW-1:0] blank_r;
  logic          dual_r;

  logic [BW-1:0] blank_last;
  logic          blank_end;
  logic          cap;

  assign blank_last = (blank_r == '0) ? '0 : blank_r - 1'b1;
  assign blank_end  = (st == BLK) && (bc == blank_last);
  assign cap        = (st == LOAD) || (blank_end && (ln == lin_r));

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      hoz_r   <= '0;
      lin_r   <= '0;
      blank_r <= '0;
      dual_r  <= 1'b0;
    end else if (cap) begin
      hoz_r   <= hoz_val;
      lin_r   <= line_val;
      blank_r <= blank_len;
      dual_r  <= dual_scan;
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= LOAD;
      div <= '0;
      xf  <= '0;
      ln  <= '0;
      bc  <= '0;
    end else begin
      case (st)
        LOAD: begin
          div <= '0;
          xf  <= '0;
          ln  <= '0;
          bc  <= '0;
          st  <= ACT;
        end
        ACT: begin
          if (div == DW'(DIV - 1)) begin
            div <= '0;
            if (xf == hoz_r) begin
              xf <= '0;
              bc <= '0;
              st <= BLK;
            end else begin
              xf <= xf + 1'b1;
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        BLK: begin
          if (blank_end) begin
            bc <= '0;
            st <= ACT;
            ln <= (ln == lin_r) ? '0 : ln + 1'b1;
          end else begin
            bc <= bc + 1'b1;
          end
        end
        default: st <= LOAD;
      endcase
    end
  end

  assign vclk      = (st == ACT) && (div >= DW'(HALF));
  assign data_req  = (st == ACT) && (div == DW'(HALF - 1));
  assign vline     = (st == BLK) && (bc < BW'(VLINE_W));
  assign vframe    = vline && (ln == '0);
  assign scan_dual = dual_r;

endmodule

// File: rtl/stn_timing_gen_chk.sv
module stn_timing_gen_chk #(
  parameter int HW = 10,
  parameter int VW = 10,
  parameter int BW = 8
) (
  input logic          mclk,
  input logic          rst_n,
  input logic          vclk,
  input logic          data_req,
  input logic          vline,
  input logic          vframe,
  input logic          scan_dual,
  input logic [1:0]    st,
  input logic          cap,
  input logic [HW-1:0] hoz_r,
  input logic [VW-1:0] lin_r,
  input logic [BW-1:0] blank_r
);
  a_r4_req_before_rise: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(vclk) |-> $past(data_req));

  a_r4_req_single: assert property (@(posedge mclk) disable iff (!rst_n)
    data_req |=> !data_req);

  a_r3_req_while_low: assert property (@(posedge mclk) disable iff (!rst_n)
    data_req |-> !vclk);

  a_r2_vclk_in_active: assert property (@(posedge mclk) disable iff (!rst_n)
    vclk |-> (st == 2'd1));

  a_r6_vline_quiet: assert property (@(posedge mclk) disable iff (!rst_n)
    vline |-> (!vclk && !data_req));

  a_r7_vframe_in_vline: assert property (@(posedge mclk) disable iff (!rst_n)
    vframe |-> vline);

  a_r8_fields_held: assert property (@(posedge mclk) disable iff (!rst_n)
    !$past(cap) |-> $stable({hoz_r, lin_r, blank_r}));

  a_r9_mode_held: assert property (@(posedge mclk) disable iff (!rst_n)
    !$past(cap) |-> $stable(scan_dual));

  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (!vclk && !data_req && !vline && !vframe && !scan_dual);
  end
endmodule

bind stn_timing_gen stn_timing_gen_chk #(.HW(HW), .VW(VW), .BW(BW)) u_chk (
  .mclk(mclk), .rst_n(rst_n), .vclk(vclk), .data_req(data_req), .vline(vline),
  .vframe(vframe), .scan_dual(scan_dual), .st(st), .cap(cap),
  .hoz_r(hoz_r), .lin_r(lin_r), .blank_r(blank_r)
);

// File: tb/stn_timing_gen_tb.sv
`timescale 1ns/1ps
module stn_timing_gen_tb;
  localparam int DIV = 4;
  localparam int VLINE_W = 2;
  localparam int HW = 10, VW = 10, BW = 8;

  typedef struct {
    int xf;
    int period;
    int w;
    bit vf;
    bit dual;
  } item_t;

  logic mclk = 0;
  logic rst_n = 0;
  logic [HW-1:0] hoz_val = '0;
  logic [VW-1:0] line_val = '0;
  logic [BW-1:0] blank_len = '0;
  logic dual_scan = 0;
  logic vclk, data_req, vline, vframe, scan_dual;

  item_t q[$];
  int checks = 0, errors = 0;
  int vf_cnt = 0;
  int prev_b = 0;
  bit first_push = 1;
  bit done = 0;

  always #2.5 mclk = ~mclk;

  stn_timing_gen #(.DIV(DIV), .VLINE_W(VLINE_W), .HW(HW), .VW(VW), .BW(BW)) u_dut (
    .mclk(mclk), .rst_n(rst_n), .hoz_val(hoz_val), .line_val(line_val),
    .blank_len(blank_len), .dual_scan(dual_scan), .vclk(vclk), .data_req(data_req),
    .vline(vline), .vframe(vframe), .scan_dual(scan_dual)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_cfg(input int h, input int l, input int b, input bit d, input int nfr);
    hoz_val = HW'(h); line_val = VW'(l); blank_len = BW'(b); dual_scan = d;
    for (int f = 0; f < nfr; f++) begin
      for (int k = 0; k <= l; k++) begin
        item_t it;
        int beff;
        beff = (b == 0) ? 1 : b;
        it.xf = h + 1;
        it.period = first_push ? -1 : prev_b + (h + 1) * DIV;
        it.w = (VLINE_W < beff) ? VLINE_W : beff;
        it.vf = (k == 0);
        it.dual = d;
        q.push_back(it);
        prev_b = beff;
        first_push = 0;
      end
    end
  endtask

  // monitor
  int rises = 0, since = 0, hi_run = 0, vl_w = 0, exp_w = 0;
  bit p_vclk = 0, p_vline = 0, p_req = 0, seen_line = 0;
  always @(negedge mclk) begin
    if (rst_n && !done) begin
      if (vclk && !p_vclk) begin
        rises++;
        check("R4 data_req before vclk rise", int'(p_req), 1);
        hi_run = 0;
      end
      if (vclk) hi_run++;
      if (!vclk && p_vclk) check("R3 vclk high time", hi_run, DIV / 2);
      if (vline && !p_vline) begin
        if (q.size() > 0) begin
          item_t it;
          it = q.pop_front();
          check("R2 transfers per line", rises, it.xf);
          if (seen_line && it.period >= 0) check("R5 line pulse spacing", since, it.period);
          check("R7 vframe on first line", int'(vframe), int'(it.vf));
          check("R8/R9 captured mode", int'(scan_dual), int'(it.dual));
          exp_w = it.w;
        end
        if (vframe) vf_cnt++;
        seen_line = 1;
        rises = 0;
        since = 0;
        vl_w = 0;
      end
      if (vline) vl_w++;
      if (!vline && p_vline) check("R6 vline width", vl_w, exp_w);
      since++;
      p_vclk = vclk; p_vline = vline; p_req = data_req;
    end
  end

  initial begin
    repeat (200000) @(posedge mclk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    push_cfg(5, 3, 10, 0, 2);
    repeat (3) @(negedge mclk);
    // R1 reset state
    check("R1 vclk in reset", int'(vclk), 0);
    check("R1 data_req in reset", int'(data_req), 0);
    check("R1 vline in reset", int'(vline), 0);
    check("R1 vframe in reset", int'(vframe), 0);
    check("R1 scan_dual in reset", int'(scan_dual), 0);
    rst_n = 1;
    base = 0;
    wait (vf_cnt == base + 2); base += 2;
    push_cfg(2, 1, 0, 1, 2);
    wait (vf_cnt == base + 2); base += 2;
    push_cfg(0, 0, 1, 0, 3);
    wait (vf_cnt == base + 3); base += 3;
    push_cfg(7, 2, 3, 1, 2);
    wait (vf_cnt == base + 2); base += 2;
    push_cfg(3, 1, 2, 0, 1);
    wait (q.size() == 0);
    repeat (40) @(negedge mclk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule